// File: doc/BRIEF.md
# Phase-coherent FSK tone synthesizer

This block produces the digital waveform of a 1200-baud frequency-shift-keyed transmitter. It runs from one master clock of nominally 3.1872 MHz. A reloadable segment divider sets how long the synthesizer stays on each of the 16 phase steps of one sine period. The transmit data bit picks the reload value: a 1 gives the lower (mark) tone of about 1302 Hz, and a 0 gives the higher (space) tone of about 2097 Hz. A change of the data bit only changes how fast the phase index moves. The index is never reset, so the tone changes without a phase jump. Every output frequency scales with the master clock.

The sample is an 8-bit signed code taken from a quarter-wave table, and the other three quarters come from symmetry. A one-cycle strobe marks each new sample, so a converter downstream can latch it. When the active-low transmit enable is high, the block is in standby and holds the code at mid-scale (zero). The same master clock also drives a free-running divider that gives a 1200 Hz square-wave reference for system timing.

Top module: `fsk_tone_synth`

## Requirements
- R1: While reset is asserted, `sample` is 0, `sample_vld` is 0 and `ref_1200` is 0.
- R2: With `tx_bit` = 1 (mark), consecutive `sample_vld` pulses are exactly 153 clock cycles apart, which gives about 1302 Hz from 16 steps.
- R3: With `tx_bit` = 0 (space), consecutive `sample_vld` pulses are exactly 95 clock cycles apart, which gives about 2097 Hz from 16 steps.
- R4: The length of a step is set by the `tx_bit` value sampled at the clock edge that starts the step (the edge on which `sample` updates). A change of `tx_bit` in the middle of a step does not shorten or lengthen that step.
- R5: On each step the phase index advances by one, modulo 16, and `sample` shows the signed code for that index. The codes for indices 0 to 15 are 0, 49, 90, 117, 127, 117, 90, 49, 0, -49, -90, -117, -127, -117, -90, -49. The index is not reset when `tx_bit` changes, and the code -128 never appears.
- R6: `sample_vld` is high for exactly one cycle per step, in the cycle in which `sample` takes its new value. Outside standby transitions, `sample` does not change in any other cycle.
- R7: A clock edge that sees `tx_en_n` = 1 makes `sample` 0 and `sample_vld` 0 in the following cycle.
- R8: After standby, the phase index restarts at 0. The first step that follows takes its length from the `tx_bit` value seen at the last standby edge.
- R9: `ref_1200` toggles every 1328 clock cycles, whatever the state of `tx_bit` and `tx_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, nominally 3.1872 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_bit | input | 1 | Serial transmit data: 1 selects the mark tone, 0 the space tone |
| tx_en_n | input | 1 | Active-low transmit enable; high holds the block in standby |
| sample | output | 8 | Signed sine sample code, two's complement |
| sample_vld | output | 1 | One-cycle strobe for a new sample |
| ref_1200 | output | 1 | 1200 Hz reference square wave |

## Verification
Two events can land on the same clock edge: a change of the data bit and the segment divider's terminal count. The entry into standby can also land on that terminal-count edge. Random stimulus produces these collisions on purpose, because the bench looks at its own model's step counter and, on the cycle just before a step ends, flips `tx_bit` or raises `tx_en_n` with a raised probability. The bench then judges the result from the spacing to the following strobe and from the sample codes. A data flip on the terminal edge must set the length of the new step. A standby on that edge must give a zero code with no strobe, and the phase must then restart at index 0.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

  // 16 phase steps per sine period
  localparam int PHASE_W = 4;
  localparam int QTR_W   = PHASE_W - 2;

  typedef enum logic {
    TONE_SPACE = 1'b0,
    TONE_MARK  = 1'b1
  } tone_e;

  // sin(k * 22.5 deg) scaled by 1024, k = 0..4 (one quarter wave)
  function automatic int qtr_num(input int k);
    case (k)
      0:       return 0;
      1:       return 392;
      2:       return 724;
      3:       return 946;
      default: return 1024;
    endcase
  endfunction

endpackage

// File: rtl/fsk_rst_sync.sv
module fsk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/fsk_seg_divider.sv
module fsk_seg_divider #(
  parameter int MARK_DIV  = 153,
  parameter int SPACE_DIV = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic tx_bit,
  output logic seg_tick
);
  import fsk_tone_pkg::*;

  localparam int MAX_DIV = (MARK_DIV > SPACE_DIV) ? MARK_DIV : SPACE_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam logic [CNT_W-1:0] MARK_LD  = CNT_W'(MARK_DIV - 1);
  localparam logic [CNT_W-1:0] SPACE_LD = CNT_W'(SPACE_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;
  logic [CNT_W-1:0] reload_val;

  // Data is only consulted when a new segment starts
  assign reload_val = (tone_e'(tx_bit) == TONE_MARK) ? MARK_LD : SPACE_LD;
  assign at_end     = (cnt_q == '0);

  always_comb begin
    cnt_d    = cnt_q;
    seg_tick = 1'b0;
    if (standby) begin
      cnt_d = reload_val;
    end else if (at_end) begin
      seg_tick = 1'b1;
      cnt_d    = reload_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= MARK_LD;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fsk_phase_sine.sv
module fsk_phase_sine #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby,
  input  logic                step,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_vld
);
  import fsk_tone_pkg::*;

  localparam int QTR_STEPS = 1 << QTR_W;
  localparam int LUT_N     = 1 << (QTR_W + 1);
  localparam int MAG_W     = SAMPLE_W - 1;
  localparam int AMP       = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] qtr_lut [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    if (g <= QTR_STEPS) begin : g_val
      assign qtr_lut[g] = MAG_W'((AMP * qtr_num(g) + 512) / 1024);
    end else begin : g_pad
      assign qtr_lut[g] = '0;
    end
  end

  logic [PHASE_W-1:0]  idx_q, idx_d;
  logic [1:0]          quad;
  logic [QTR_W-1:0]    offs;
  logic [QTR_W:0]      pos;
  logic [MAG_W-1:0]    mag;
  logic [SAMPLE_W-1:0] code_d;
  logic [SAMPLE_W-1:0] sample_q;
  logic                vld_q;
  logic                load_en;

  // Phase index next state
  always_comb begin
    idx_d = idx_q;
    if (standby) begin
      idx_d = '0;
    end else if (step) begin
      idx_d = idx_q + 1'b1;
    end
  end

  // Quarter-wave symmetry: odd quadrants mirror, upper half negates
  always_comb begin
    quad = idx_d[PHASE_W-1 -: 2];
    offs = idx_d[QTR_W-1:0];
    if (quad[0]) begin
      pos = (QTR_W + 1)'(QTR_STEPS) - {1'b0, offs};
    end else begin
      pos = {1'b0, offs};
    end
    mag = qtr_lut[pos];
    if (quad[1]) begin
      code_d = -{1'b0, mag};
    end else begin
      code_d = {1'b0, mag};
    end
  end

  assign load_en = standby | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= step & ~standby;
      if (load_en) begin
        idx_q    <= idx_d;
        sample_q <= code_d;
      end
    end
  end

  assign sample     = sample_q;
  assign sample_vld = vld_q;

endmodule

// File: rtl/fsk_ref_divider.sv
module fsk_ref_divider #(
  parameter int HALF_PERIOD = 1328
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_out
);

  localparam int CNT_W = $clog2(HALF_PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ref_q, ref_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    ref_d = ref_q;
    if (wrap) begin
      cnt_d = '0;
      ref_d = ~ref_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  assign ref_out = ref_q;

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth #(
  parameter int MARK_DIV   = 153,
  parameter int SPACE_DIV  = 95,
  parameter int REF_HALF   = 1328,
  parameter int SAMPLE_W   = 8,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_bit,
  input  logic                tx_en_n,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_vld,
  output logic                ref_1200
);

  logic srst_n;
  logic seg_tick;
  logic standby;

  assign standby = tx_en_n;

  fsk_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fsk_seg_divider #(
    .MARK_DIV  (MARK_DIV),
    .SPACE_DIV (SPACE_DIV)
  ) u_div (
    .clk      (clk),
    .rst_n    (srst_n),
    .standby  (standby),
    .tx_bit   (tx_bit),
    .seg_tick (seg_tick)
  );

  fsk_phase_sine #(
    .SAMPLE_W (SAMPLE_W)
  ) u_sine (
    .clk        (clk),
    .rst_n      (srst_n),
    .standby    (standby),
    .step       (seg_tick),
    .sample     (sample),
    .sample_vld (sample_vld)
  );

  fsk_ref_divider #(
    .HALF_PERIOD (REF_HALF)
  ) u_ref (
    .clk     (clk),
    .rst_n   (srst_n),
    .ref_out (ref_1200)
  );

endmodule

// File: rtl/fsk_tone_synth_chk.sv
module fsk_tone_synth_chk #(
  parameter int MARK_DIV  = 153,
  parameter int SPACE_DIV = 95,
  parameter int SAMPLE_W  = 8
) (
  input logic                clk,
  input logic                srst_n,
  input logic                tx_en_n,
  input logic [SAMPLE_W-1:0] sample,
  input logic                sample_vld
);

  logic [15:0] gap_q;

  // Cycles since the edge that began the current step
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      gap_q <= '0;
    end else if (tx_en_n) begin
      gap_q <= '0;
    end else if (sample_vld) begin
      gap_q <= 16'd1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_SEG_LEN: assert property (@(posedge clk) disable iff (!srst_n)
    sample_vld |-> (gap_q == 16'(MARK_DIV) || gap_q == 16'(SPACE_DIV))); // R2

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    sample_vld |=> !sample_vld); // R6

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!srst_n)
    (!sample_vld && !$past(tx_en_n)) |-> $stable(sample)); // R6

  AST_STANDBY_MID: assert property (@(posedge clk) disable iff (!srst_n)
    tx_en_n |=> (sample == '0 && !sample_vld)); // R7

  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!srst_n)
    sample != {1'b1, {(SAMPLE_W-1){1'b0}}}); // R5

endmodule

bind fsk_tone_synth fsk_tone_synth_chk #(
  .MARK_DIV  (MARK_DIV),
  .SPACE_DIV (SPACE_DIV),
  .SAMPLE_W  (SAMPLE_W)
) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .tx_en_n    (tx_en_n),
  .sample     (sample),
  .sample_vld (sample_vld)
);

// File: tb/fsk_tone_synth_test.sv
`timescale 1ns/1ps
module fsk_tone_synth_test;

  localparam int MARK_LEN  = 153;
  localparam int SPACE_LEN = 95;
  localparam int REF_LEN   = 1328;
  localparam int RUN_CYC   = 60000;
  localparam int WDOG_CYC  = 200000;

  logic       clk;
  logic       rst_n;
  logic       tx_bit;
  logic       tx_en_n;
  logic [7:0] sample;
  logic       sample_vld;
  logic       ref_1200;

  int n_tests;
  int n_fail;
  bit done;

  fsk_tone_synth uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_bit     (tx_bit),
    .tx_en_n    (tx_en_n),
    .sample     (sample),
    .sample_vld (sample_vld),
    .ref_1200   (ref_1200)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_code(input int idx);
    case (idx % 16)
      0: return 0;     1: return 49;    2: return 90;    3: return 117;
      4: return 127;   5: return 117;   6: return 90;    7: return 49;
      8: return 0;     9: return -49;   10: return -90;  11: return -117;
      12: return -127; 13: return -117; 14: return -90;  default: return -49;
    endcase
  endfunction

  function automatic int seg_len(input logic b);
    return b ? MARK_LEN : SPACE_LEN;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Watchdog
  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int   exp_idx;
    int   cyc;
    int   cur_len;
    logic prev_bit;
    logic prev_en_n;
    bit   mid_change;
    bit   after_sb;
    int   sb_left;
    logic last_ref;
    int   ref_cnt;
    bit   ref_seen;
    string tag;

    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    void'($urandom(32'h5EED_0A17));

    rst_n   = 1'b0;
    tx_bit  = 1'b1;
    tx_en_n = 1'b1;

    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      check(sample == 8'd0, "R1 sample", int'(sample), 0);
      check(sample_vld == 1'b0, "R1 vld", int'(sample_vld), 0);
      check(ref_1200 == 1'b0, "R1 ref", int'(ref_1200), 0);
    end
    rst_n = 1'b1;
    // standby across the internal reset release
    repeat (5) @(negedge clk);

    prev_bit   = tx_bit;
    prev_en_n  = tx_en_n;
    exp_idx    = 0;
    cyc        = 0;
    cur_len    = seg_len(tx_bit);
    mid_change = 1'b0;
    after_sb   = 1'b1;
    sb_left    = 0;
    last_ref   = ref_1200;
    ref_cnt    = 0;
    ref_seen   = 1'b0;
    tx_en_n    = 1'b0;
    prev_en_n  = 1'b0;

    for (int k = 0; k < RUN_CYC; k++) begin
      @(negedge clk);

      // reference divider (R9)
      if (ref_1200 != last_ref) begin
        if (ref_seen) check(ref_cnt + 1 == REF_LEN, "R9", ref_cnt + 1, REF_LEN);
        ref_seen = 1'b1;
        ref_cnt  = 0;
        last_ref = ref_1200;
      end else begin
        ref_cnt++;
      end

      if (prev_en_n) begin
        check(sample == 8'd0, "R7 sample", int'($signed(sample)), 0);
        check(sample_vld == 1'b0, "R7 vld", int'(sample_vld), 0);
        exp_idx    = 0;
        cyc        = 0;
        cur_len    = seg_len(prev_bit);
        mid_change = 1'b0;
        after_sb   = 1'b1;
      end else begin
        cyc++;
        if (cyc == cur_len) begin
          if (mid_change)          tag = "R4";
          else if (cur_len == MARK_LEN) tag = "R2";
          else                     tag = "R3";
          check(sample_vld == 1'b1, tag, int'(sample_vld), 1);
          exp_idx = (exp_idx + 1) % 16;
          check(int'($signed(sample)) == exp_code(exp_idx), after_sb ? "R8" : "R5",
                int'($signed(sample)), exp_code(exp_idx));
          after_sb   = 1'b0;
          cyc        = 0;
          cur_len    = seg_len(prev_bit);
          mid_change = 1'b0;
        end else begin
          check(sample_vld == 1'b0, "R6 vld", int'(sample_vld), 0);
          check(int'($signed(sample)) == exp_code(exp_idx), "R6 hold",
                int'($signed(sample)), exp_code(exp_idx));
        end
      end

      // drive stimulus for the next edge
      if (sb_left > 0) begin
        sb_left--;
        tx_en_n = (sb_left > 0);
      end else if (!prev_en_n && cyc == cur_len - 1 && ($urandom % 48) == 0) begin
        tx_en_n = 1'b1;              // standby on a terminal-count edge
        sb_left = 1 + ($urandom % 6);
      end else if (($urandom % 3000) == 0) begin
        tx_en_n = 1'b1;
        sb_left = 1 + ($urandom % 20);
      end

      if (!prev_en_n && cyc == cur_len - 1 && ($urandom % 3) == 0) begin
        tx_bit = ~tx_bit;            // data flip on a terminal-count edge
      end else if (($urandom % 80) == 0) begin
        tx_bit = ~tx_bit;
        if (cyc != cur_len - 1) mid_change = 1'b1;
      end

      prev_bit  = tx_bit;
      prev_en_n = tx_en_n;
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule